// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits between a group of sixteen lanes and a scratchpad split into sixteen single-ported banks, each one 32-bit word wide. One request group carries a word address and a valid bit for every lane. Bank selection uses the low address bits: word address `a` lives in bank `a mod 16`, at row `a / 16`. Each bank serves one row per clock. The serializer therefore spreads the group over as many cycles as its most crowded bank needs.

Lanes that name the same word are merged, so the bank reads that word once and the result goes to all of them. Conflicts are only resolved inside one group, and the block holds one group at a time. Bank RAMs return data one cycle after the read strobe. The serializer remembers which lanes each read serves and sends the returned word only to those lanes. When the whole group has finished, a single-cycle done pulse presents the sixteen result words together.

Top module: `ssb_serializer`

## Requirements
- R1: Lane address `a` is read through bank port `a[3:0]` at row `a[7:4]`, and the data returned to that lane equals the scratchpad word at `a`.
- R2: If every active lane targets a different bank, the group takes one bank cycle (K = 1). Latency is counted from the accepting edge. With K the largest number of distinct addresses in any one bank, `rsp_done` is high in the (K+2)-th cycle after acceptance.
- R3: If all lanes read the same address, this is a broadcast with K = 1: one bank read serves every lane.
- R4: A linear pattern with stride s over 16 lanes gives K = 1 for odd s, K = 2 for s = 2, K = 8 for s = 8 and K = 16 for s = 16.
- R5: In each cycle a bank reads the address of its lowest-numbered lane that is still pending.
- R6: All pending lanes that share the chosen address are served in that same cycle, so the total number of bank reads equals the number of distinct addresses among the active lanes.
- R7: A lane whose valid bit is 0 causes no bank read, and its response word is zero.
- R8: `req_ready` is 1 when idle, drops to 0 in the cycle after acceptance, and stays 0 until the cycle after `rsp_done`.
- R9: `rsp_done` lasts exactly one cycle. `rsp_data` holds the complete results during that cycle.
- R10: A group with no valid lane makes no reads and raises `rsp_done` in the first cycle after acceptance.
- R11: After reset `req_ready` is 1, `rsp_done` is 0 and no bank read strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request group offered |
| req_ready | output | 1 | Serializer idle, able to take a group |
| req_lane_valid | input | 16 | Per-lane active bits |
| req_addr | input | 128 | Lane word addresses, lane l at bits [8l+7:8l] |
| bank_rd_en | output | 16 | Per-bank read strobes |
| bank_rd_addr | output | 64 | Per-bank row, bank b at bits [4b+3:4b] |
| bank_rd_data | input | 512 | Per-bank read data one cycle after the strobe, bank b at [32b+31:32b] |
| rsp_done | output | 1 | Single-cycle group completion pulse |
| rsp_data | output | 512 | Per-lane result words, lane l at [32l+31:32l] |

## Verification
The bench sends linear groups with strides 1, 3, 2, 8, 16 and 0. Each stride produces a different bank multiplicity, so a fault in bank selection or in serialization shows up as a latency other than K+1. Partly masked groups and an empty group show whether invalid lanes are really skipped. One hand-placed group mixes repeated and distinct addresses in a single bank; its order of reads into bank 0 shows whether the lowest pending lane is chosen and whether duplicates are merged. A broadcast group with one odd lane checks that merging works alongside a real conflict.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic {
    SSB_IDLE = 1'b0,
    SSB_BUSY = 1'b1
  } ssb_state_e;
endpackage

// File: rtl/ssb_bank_pick.sv
module ssb_bank_pick #(
  parameter int LANES     = 16,
  parameter int ADDR_W    = 8,
  parameter int BANK_BITS = 4,
  parameter int BANK_IDX  = 0,
  localparam int ROW_W    = ADDR_W - BANK_BITS
) (
  input  logic [LANES-1:0]        pending,
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  output logic                    rd_en,
  output logic [ROW_W-1:0]        rd_row,
  output logic [LANES-1:0]        serve
);
  logic              found;
  logic [ADDR_W-1:0] sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int l = 0; l < LANES; l++) begin
      if (!found && pending[l] &&
          lane_addr[l*ADDR_W +: BANK_BITS] == BANK_BITS'(BANK_IDX)) begin
        found = 1'b1;
        sel   = lane_addr[l*ADDR_W +: ADDR_W];
      end
    end
    for (int l = 0; l < LANES; l++) begin
      serve[l] = found && pending[l] && (lane_addr[l*ADDR_W +: ADDR_W] == sel);
    end
    rd_en  = found;
    rd_row = sel[ADDR_W-1:BANK_BITS];
  end
endmodule

// File: rtl/ssb_resp_regs.sv
module ssb_resp_regs #(
  parameter int LANES     = 16,
  parameter int ADDR_W    = 8,
  parameter int BANK_BITS = 4,
  parameter int DATA_W    = 32,
  localparam int BANKS    = 1 << BANK_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic [LANES-1:0]        cap_mask,
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  input  logic [BANKS*DATA_W-1:0] bank_rd_data,
  output logic [LANES*DATA_W-1:0] lane_data
);
  logic [LANES*DATA_W-1:0] data_d;

  always_comb begin
    data_d = lane_data;
    for (int l = 0; l < LANES; l++) begin
      if (clear) begin
        data_d[l*DATA_W +: DATA_W] = '0;
      end else if (cap_mask[l]) begin
        data_d[l*DATA_W +: DATA_W] =
          bank_rd_data[int'(lane_addr[l*ADDR_W +: BANK_BITS])*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_data <= '0;
    end else if (clear || (cap_mask != '0)) begin
      lane_data <= data_d;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (lane_data == '0)); // R7

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && cap_mask == '0) |=> $stable(lane_data)); // R9
endmodule

// File: rtl/ssb_serializer.sv
module ssb_serializer
  import ssb_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int ADDR_W    = 8,
  parameter int BANK_BITS = 4,
  parameter int DATA_W    = 32,
  localparam int BANKS    = 1 << BANK_BITS,
  localparam int ROW_W    = ADDR_W - BANK_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_lane_valid,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  output logic [BANKS-1:0]        bank_rd_en,
  output logic [BANKS*ROW_W-1:0]  bank_rd_addr,
  input  logic [BANKS*DATA_W-1:0] bank_rd_data,
  output logic                    rsp_done,
  output logic [LANES*DATA_W-1:0] rsp_data
);
  ssb_state_e              state_q, state_d;
  logic [LANES-1:0]        pending_q, pending_d;
  logic [LANES-1:0]        infl_q, infl_d;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        serve_b [BANKS];
  logic [LANES-1:0]        serve_all;
  logic                    accept;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    ssb_bank_pick #(
      .LANES(LANES), .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .BANK_IDX(b)
    ) u_pick (
      .pending  (pending_q),
      .lane_addr(addr_q),
      .rd_en    (bank_rd_en[b]),
      .rd_row   (bank_rd_addr[b*ROW_W +: ROW_W]),
      .serve    (serve_b[b])
    );
  end

  always_comb begin
    serve_all = '0;
    for (int b = 0; b < BANKS; b++) serve_all = serve_all | serve_b[b];
  end

  assign req_ready = (state_q == SSB_IDLE);
  assign accept    = req_valid && req_ready;
  assign rsp_done  = (state_q == SSB_BUSY) && (pending_q == '0) && (infl_q == '0);

  always_comb begin
    state_d   = state_q;
    pending_d = pending_q & ~serve_all;
    infl_d    = (state_q == SSB_BUSY) ? serve_all : '0;
    if (accept) begin
      state_d   = SSB_BUSY;
      pending_d = req_lane_valid;
    end else if (rsp_done) begin
      state_d = SSB_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SSB_IDLE;
      pending_q <= '0;
      infl_q    <= '0;
    end else begin
      state_q   <= state_d;
      pending_q <= pending_d;
      infl_q    <= infl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
    end
  end

  ssb_resp_regs #(
    .LANES(LANES), .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .DATA_W(DATA_W)
  ) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (accept),
    .cap_mask    (infl_q),
    .lane_addr   (addr_q),
    .bank_rd_data(bank_rd_data),
    .lane_data   (rsp_data)
  );

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready)); // R9

  AST_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SSB_BUSY && pending_q != '0) |=> (pending_q != $past(pending_q))); // R4

  AST_PENDING_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SSB_BUSY) |=> ((pending_q & ~$past(pending_q)) == '0)); // R6

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SSB_IDLE) |-> (bank_rd_en == '0)); // R11
endmodule

// File: tb/ssb_serializer_tb.sv
`timescale 1ns/1ps
module ssb_serializer_tb;
  localparam int LANES = 16;
  localparam int ADDR_W = 8;
  localparam int BANK_BITS = 4;
  localparam int DATA_W = 32;
  localparam int BANKS = 16;
  localparam int ROW_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LANES-1:0] req_lane_valid = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic [BANKS-1:0] bank_rd_en;
  logic [BANKS*ROW_W-1:0] bank_rd_addr;
  logic [BANKS*DATA_W-1:0] bank_rd_data;
  logic rsp_done;
  logic [LANES*DATA_W-1:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int rd_total = 0;
  int b0_n = 0;
  logic [ROW_W-1:0] b0_log [64];

  always #2 clk = ~clk;

  ssb_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lane_valid(req_lane_valid), .req_addr(req_addr),
    .bank_rd_en(bank_rd_en), .bank_rd_addr(bank_rd_addr),
    .bank_rd_data(bank_rd_data), .rsp_done(rsp_done), .rsp_data(rsp_data)
  );

  function automatic logic [31:0] word(input int a);
    return {8'hC3, 8'(a), 16'(a * 37 + 5)};
  endfunction

  logic [DATA_W-1:0] ram_q [BANKS];
  for (genvar b = 0; b < BANKS; b++) begin : g_ram
    assign bank_rd_data[b*DATA_W +: DATA_W] = ram_q[b];
    always @(posedge clk) begin
      if (bank_rd_en[b]) ram_q[b] <= word(int'(bank_rd_addr[b*ROW_W +: ROW_W]) * 16 + b);
    end
  end

  always @(posedge clk) begin
    rd_total <= rd_total + $countones(bank_rd_en);
    if (bank_rd_en[0]) begin
      b0_log[b0_n % 64] <= bank_rd_addr[ROW_W-1:0];
      b0_n <= b0_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs one group; expected values derived from the requirements.
  task automatic run_group(input logic [ADDR_W-1:0] a [LANES], input logic [LANES-1:0] m,
                           input int exp_k, input string req);
    int cnt;
    int distinct;
    int rd0;
    int exp_lat;
    bit dup;
    bit data_ok;
    @(negedge clk);
    for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = a[l];
    req_lane_valid = m;
    req_valid = 1'b1;
    rd0 = rd_total;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8", "ready low after accept", req_ready, 0);
    cnt = 0;
    while (!rsp_done && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    exp_lat = (exp_k == 0) ? 0 : exp_k + 1;
    check(cnt == exp_lat, req, "latency", cnt, exp_lat);
    data_ok = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      logic [31:0] e;
      e = m[l] ? word(int'(a[l])) : 32'h0;
      if (rsp_data[l*DATA_W +: DATA_W] !== e) begin
        data_ok = 1'b0;
        check(1'b0, m[l] ? "R1" : "R7", "lane data", rsp_data[l*DATA_W +: DATA_W], e);
      end
    end
    if (data_ok) check(1'b1, "R1", "lane data", 0, 0);
    distinct = 0;
    for (int l = 0; l < LANES; l++) begin
      dup = 1'b0;
      for (int k = 0; k < l; k++) if (m[k] && a[k] == a[l]) dup = 1'b1;
      if (m[l] && !dup) distinct++;
    end
    check(rd_total - rd0 == distinct, "R6", "bank read count", rd_total - rd0, distinct);
    @(negedge clk);
    check(rsp_done == 1'b0 && req_ready == 1'b1, "R9", "done single pulse, ready back",
          {rsp_done, req_ready}, 2'b01);
  endtask

  // {base, stride, lane mask, expected K}
  localparam logic [39:0] VEC [8] = '{
    {8'd0,  8'd1,  16'hFFFF, 8'd1},   // R2 all banks distinct
    {8'd5,  8'd0,  16'hFFFF, 8'd1},   // R3 broadcast
    {8'd0,  8'd2,  16'hFFFF, 8'd2},   // R4 stride 2
    {8'd3,  8'd8,  16'hFFFF, 8'd8},   // R4 stride 8
    {8'd1,  8'd3,  16'hFFFF, 8'd1},   // R4 odd stride
    {8'd0,  8'd16, 16'hFFFF, 8'd16},  // R4 single bank
    {8'd7,  8'd2,  16'h00FF, 8'd1},   // R7 half masked
    {8'd9,  8'd16, 16'h0000, 8'd0}    // R10 empty group
  };
  localparam string VREQ [8] = '{"R2", "R3", "R4", "R4", "R4", "R4", "R7", "R10"};

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] a [LANES];
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && rsp_done == 1'b0 && bank_rd_en == '0, "R11",
          "reset outputs", {req_ready, rsp_done, bank_rd_en}, 18'h20000);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && bank_rd_en == '0, "R11", "idle after release",
          {req_ready, bank_rd_en}, 17'h10000);

    for (int v = 0; v < 8; v++) begin
      for (int l = 0; l < LANES; l++)
        a[l] = ADDR_W'(int'(VEC[v][39:32]) + int'(VEC[v][31:24]) * l);
      run_group(a, VEC[v][23:8], int'(VEC[v][7:0]), VREQ[v]);
    end

    // R5: bank 0 order follows lowest pending lane; duplicates merged (R6)
    for (int l = 0; l < LANES; l++) a[l] = ADDR_W'(l + 1);
    a[0] = 8'd32; a[1] = 8'd16; a[2] = 8'd32; a[3] = 8'd0;
    begin
      int s;
      s = b0_n;
      run_group(a, 16'h000F, 3, "R5");
      check(b0_n - s == 3, "R5", "bank0 read count", b0_n - s, 3);
      check(b0_log[s % 64] == 4'd2, "R5", "first bank0 row", b0_log[s % 64], 2);
      check(b0_log[(s + 1) % 64] == 4'd1, "R5", "second bank0 row", b0_log[(s + 1) % 64], 1);
      check(b0_log[(s + 2) % 64] == 4'd0, "R5", "third bank0 row", b0_log[(s + 2) % 64], 0);
    end

    // R3 with R6: broadcast plus one conflicting lane in the same bank
    for (int l = 0; l < LANES; l++) a[l] = 8'd5;
    a[9] = 8'd21;
    run_group(a, 16'hFFFF, 2, "R3");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule